// File: doc/BRIEF.md
# Dynamic Bus Sizing Transfer Controller

This block moves one CPU-side transfer of one to four bytes across an external port whose data width is not known ahead of time. The transfer comes in as a request with a start address, a byte count and, for writes, up to four bytes of data. The block then runs a sequence of bus cycles. Each cycle drives a 2-bit size code that gives the number of bytes still to move. The port answers with a 2-bit acknowledge code. That code either names the width it took on this cycle (one byte or one word) or asks the block to keep the cycle open.

After each accepted cycle the block advances the address and lowers the remaining count by the number of bytes the port took. On writes it steers the next bytes in order onto the data lanes. On reads it stores the returned bytes at their positions in a result register. When the count reaches zero it pulses `done` and becomes idle again. The request side is a valid/ready handshake: `req_ready` is high only while idle, so a request that arrives during a transfer is held off until the transfer ends. The result side is a plain one-cycle strobe with no back-pressure.

Request byte k (k = 0 first) belongs to address `start + k`. It sits in bits `[8k+7:8k]` of `req_wdata` and of `rd_data`. On the port, the byte at the current address uses lane `[7:0]` and the byte after it uses lane `[15:8]`.

Top module: `dbs_xfer_ctrl`

## Requirements
- R1: While a cycle is open, `bus_siz` encodes the bytes still to move: four as 00, three as 11, two as 10, one as 01.
- R2: An acknowledge of 11 is a wait. The cycle stays open and address, size code, direction and write lanes hold unchanged for as long as 11 is presented.
- R3: An acknowledge of 10 (byte port) completes one byte. The remaining count drops by one and `bus_addr` advances by one.
- R4: An acknowledge of 00 or 01 (word port) completes two bytes, or one byte if only one was left. The address advances by the same amount.
- R5: On a write, lane `[7:0]` carries the request byte for the current address, and lane `[15:8]` carries the following request byte whenever two or more bytes remain.
- R6: On a read, each completed cycle stores lane `[7:0]` at the current byte position of `rd_data` and, on a word acknowledge with two or more bytes left, lane `[15:8]` at the next position. Positions beyond the request length read as zero.
- R7: The cycle after the last byte completes, `done` is high for exactly one clock, `bus_cyc` is low and `rd_data` holds the full result.
- R8: `req_ready` is high exactly when no transfer is in progress. A request presented while busy is not taken and does not disturb the running transfer.
- R9: While idle, `bus_cyc` is low and `bus_siz` is 00.
- R10: A transfer of N bytes takes N completed cycles on a byte port and ceil(N/2) on a word port, plus any wait cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Transfer request present |
| req_ready | output | 1 | Block is idle and takes a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | 2 | Byte count minus one (0..3 means 1..4 bytes) |
| req_wdata | input | 32 | Write bytes, byte k in bits [8k+7:8k] |
| done | output | 1 | One-cycle strobe when the transfer ends |
| rd_data | output | 32 | Gathered read bytes, byte k in bits [8k+7:8k] |
| bus_cyc | output | 1 | Bus cycle open |
| bus_we | output | 1 | Bus cycle is a write |
| bus_addr | output | ADDR_W | Current byte address |
| bus_siz | output | 2 | Remaining-byte size code |
| bus_wdata | output | 16 | Write lanes: [7:0] current byte, [15:8] next byte |
| bus_ack | input | 2 | Port reply: 11 wait, 10 byte, 0x word |
| bus_rdata | input | 16 | Read lanes from the port |

## Verification
The bench builds the block with a 16-bit address so that start addresses and the port's memory image come from simple arithmetic on the address. It sweeps every length from one to four bytes in both directions, against a byte-wide port and a word-wide port that alternates between the two word codes, with zero to two wait cycles per bus cycle. This reaches the odd-length tail on a word port, where the high lane must be ignored, as well as requests raised during waits and the exact completion cycle of each transfer.

// File: rtl/dbs_xfer_pkg.sv
package dbs_xfer_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_BUS = 1'b1} xfer_state_t;
  localparam logic [1:0] ACK_HOLD  = 2'b11;
  localparam logic [1:0] ACK_NARROW = 2'b10;
  localparam int MAX_BYTES = 4;
  localparam int PORT_LANES = 2;
endpackage

// File: rtl/dbs_size_enc.sv
module dbs_size_enc (
  input  logic [2:0] left_cnt,
  output logic [1:0] siz_code
);
  always_comb begin
    case (left_cnt)
      3'd4:    siz_code = 2'b00;
      3'd3:    siz_code = 2'b11;
      3'd2:    siz_code = 2'b10;
      3'd1:    siz_code = 2'b01;
      default: siz_code = 2'b00;
    endcase
  end
endmodule

// File: rtl/dbs_step_calc.sv
module dbs_step_calc
  import dbs_xfer_pkg::*;
(
  input  logic [1:0] ack_code,
  input  logic [2:0] left_cnt,
  output logic       advance,
  output logic [1:0] step
);
  always_comb begin
    advance = (ack_code != ACK_HOLD);
    if (ack_code == ACK_HOLD)        step = 2'd0;
    else if (ack_code == ACK_NARROW) step = 2'd1;
    else if (left_cnt >= 3'd2)       step = 2'd2;
    else                             step = 2'd1;
  end
endmodule

// File: rtl/dbs_lane_steer.sv
module dbs_lane_steer
  import dbs_xfer_pkg::*;
#(
  parameter int LANE_W = 8,
  localparam int DW = MAX_BYTES * LANE_W,
  localparam int PW = PORT_LANES * LANE_W
) (
  input  logic [DW-1:0] wbuf,
  input  logic [DW-1:0] rbuf,
  input  logic [1:0]    pos,
  input  logic [1:0]    step,
  input  logic [PW-1:0] port_rd,
  output logic [PW-1:0] port_wr,
  output logic [DW-1:0] rbuf_next
);
  logic [2:0] pos_nx;
  assign pos_nx = {1'b0, pos} + 3'd1;

  always_comb begin
    port_wr = '0;
    port_wr[LANE_W-1:0] = wbuf[pos*LANE_W +: LANE_W];
    if (pos_nx < 3'(MAX_BYTES))
      port_wr[PW-1:LANE_W] = wbuf[pos_nx[1:0]*LANE_W +: LANE_W];
  end

  for (genvar j = 0; j < MAX_BYTES; j++) begin : g_gather
    always_comb begin
      if (step != 2'd0 && pos == 2'(j))
        rbuf_next[j*LANE_W +: LANE_W] = port_rd[LANE_W-1:0];
      else if (step == 2'd2 && pos_nx == 3'(j))
        rbuf_next[j*LANE_W +: LANE_W] = port_rd[PW-1:LANE_W];
      else
        rbuf_next[j*LANE_W +: LANE_W] = rbuf[j*LANE_W +: LANE_W];
    end
  end
endmodule

// File: rtl/dbs_xfer_ctrl.sv
module dbs_xfer_ctrl
  import dbs_xfer_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_len,
  input  logic [31:0]       req_wdata,
  output logic              done,
  output logic [31:0]       rd_data,
  output logic              bus_cyc,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [1:0]        bus_siz,
  output logic [15:0]       bus_wdata,
  input  logic [1:0]        bus_ack,
  input  logic [15:0]       bus_rdata
);
  localparam int LANE_W = 8;

  xfer_state_t       state;
  logic [2:0]        left_cnt;
  logic [1:0]        pos;
  logic [ADDR_W-1:0] cur_addr;
  logic              is_wr;
  logic [31:0]       wbuf;
  logic [31:0]       rbuf;
  logic [31:0]       rbuf_next;
  logic [15:0]       lanes_out;
  logic [1:0]        siz_raw;
  logic [1:0]        step;
  logic              advance;
  logic              busy;

  assign busy = (state == ST_BUS);

  dbs_size_enc u_enc (.left_cnt(left_cnt), .siz_code(siz_raw));

  dbs_step_calc u_step (
    .ack_code(bus_ack), .left_cnt(left_cnt), .advance(advance), .step(step)
  );

  dbs_lane_steer #(.LANE_W(LANE_W)) u_lanes (
    .wbuf(wbuf), .rbuf(rbuf), .pos(pos), .step(step),
    .port_rd(bus_rdata), .port_wr(lanes_out), .rbuf_next(rbuf_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      left_cnt <= '0;
      pos      <= '0;
      cur_addr <= '0;
      is_wr    <= 1'b0;
      wbuf     <= '0;
      rbuf     <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (req_valid) begin
          state    <= ST_BUS;
          left_cnt <= {1'b0, req_len} + 3'd1;
          pos      <= '0;
          cur_addr <= req_addr;
          is_wr    <= req_write;
          wbuf     <= req_wdata;
          rbuf     <= '0;
        end
      end else if (advance) begin
        left_cnt <= left_cnt - {1'b0, step};
        pos      <= pos + step;
        cur_addr <= cur_addr + ADDR_W'(step);
        if (!is_wr) rbuf <= rbuf_next;
        if (left_cnt == {1'b0, step}) begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end
      end
    end
  end

  assign req_ready = !busy;
  assign bus_cyc   = busy;
  assign bus_we    = busy && is_wr;
  assign bus_addr  = cur_addr;
  assign bus_siz   = busy ? siz_raw : 2'b00;
  assign bus_wdata = (busy && is_wr) ? lanes_out : 16'h0000;
  assign rd_data   = rbuf;
endmodule

// File: rtl/dbs_xfer_ctrl_chk.sv
module dbs_xfer_ctrl_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              done,
  input logic              bus_cyc,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [1:0]        bus_siz,
  input logic [1:0]        bus_ack
);
  a_r2_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cyc && bus_ack == 2'b11) |=> (bus_cyc && $stable(bus_addr) && $stable(bus_siz)));

  a_r3_byte_step: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cyc && bus_ack == 2'b10 && bus_siz != 2'b01)
      |=> (bus_cyc && bus_addr == $past(bus_addr) + ADDR_W'(1)));

  a_r1_four_to_three: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cyc && bus_ack == 2'b10 && bus_siz == 2'b00) |=> (bus_siz == 2'b11));

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !bus_cyc);

  a_r8_take_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> bus_cyc);

  a_r8_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !bus_cyc);

  a_r9_idle_size: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_cyc |-> (bus_siz == 2'b00));
endmodule

bind dbs_xfer_ctrl dbs_xfer_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/dbs_xfer_ctrl_test.sv
module dbs_xfer_ctrl_test;
  localparam int CLK_P = 10;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0]    req_len = '0;
  logic [31:0]   req_wdata = '0;
  logic          done;
  logic [31:0]   rd_data;
  logic          bus_cyc;
  logic          bus_we;
  logic [AW-1:0] bus_addr;
  logic [1:0]    bus_siz;
  logic [15:0]   bus_wdata;
  logic [1:0]    bus_ack = 2'b11;
  logic [15:0]   bus_rdata = '0;

  int errs = 0;
  int checks = 0;

  always #(CLK_P/2) clk = ~clk;

  dbs_xfer_ctrl #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_len(req_len),
    .req_wdata(req_wdata), .done(done), .rd_data(rd_data), .bus_cyc(bus_cyc),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_siz(bus_siz),
    .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] mem_b(input logic [AW-1:0] a);
    return ((a[7:0] * 8'd7) + 8'd3) ^ a[15:8];
  endfunction

  task automatic xact(input int len, input bit wr, input bit wide, input int nwait,
                      input logic [AW-1:0] base);
    logic [31:0]   wd;
    logic [31:0]   expr;
    logic [AW-1:0] ea;
    int rem;
    int ncyc;
    int step;
    int exp_n;
    wd = {base, ~base} ^ 32'h5a3c_9617;
    @(negedge clk);
    chk(req_ready == 1'b1, "R8 ready when idle", 32'(req_ready), 32'd1);
    req_valid = 1'b1; req_write = wr; req_addr = base;
    req_len = 2'(len - 1); req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    rem = len; ea = base; ncyc = 0; expr = '0;
    while (rem > 0) begin
      chk(bus_cyc == 1'b1, "R9 cycle open", 32'(bus_cyc), 32'd1);
      chk(bus_siz == 2'(rem % 4), "R1 size code", 32'(bus_siz), 32'(rem % 4));
      chk(bus_addr == ea, wide ? "R4 address" : "R3 address", 32'(bus_addr), 32'(ea));
      chk(bus_we == wr, "R5 direction", 32'(bus_we), 32'(wr));
      if (wr) begin
        chk(bus_wdata[7:0] == wd[8*(len-rem) +: 8], "R5 low lane",
            32'(bus_wdata[7:0]), 32'(wd[8*(len-rem) +: 8]));
        if (rem >= 2)
          chk(bus_wdata[15:8] == wd[8*(len-rem+1) +: 8], "R5 high lane",
              32'(bus_wdata[15:8]), 32'(wd[8*(len-rem+1) +: 8]));
      end
      for (int w = 0; w < nwait; w++) begin
        bus_ack = 2'b11;
        if (w == 0) begin
          req_valid = 1'b1; req_addr = ~base; req_write = ~wr; req_len = 2'd0;
          chk(req_ready == 1'b0, "R8 busy not ready", 32'(req_ready), 32'd0);
        end
        @(negedge clk);
        req_valid = 1'b0;
        chk(bus_cyc && bus_siz == 2'(rem % 4) && bus_addr == ea, "R2 wait holds",
            {bus_cyc, 13'd0, bus_siz, bus_addr}, {1'b1, 13'd0, 2'(rem % 4), ea});
        if (wr)
          chk(bus_wdata[7:0] == wd[8*(len-rem) +: 8], "R2 lanes hold",
              32'(bus_wdata[7:0]), 32'(wd[8*(len-rem) +: 8]));
      end
      bus_ack = wide ? {1'b0, ea[1]} : 2'b10;
      bus_rdata = wide ? {mem_b(ea + AW'(1)), mem_b(ea)} : {8'hEE, mem_b(ea)};
      step = (wide && rem >= 2) ? 2 : 1;
      for (int k = 0; k < step; k++) expr[8*(len-rem+k) +: 8] = mem_b(ea + AW'(k));
      @(negedge clk);
      bus_ack = 2'b11;
      ncyc++;
      rem -= step;
      ea += AW'(step);
    end
    chk(done == 1'b1, "R7 done strobe", 32'(done), 32'd1);
    chk(!bus_cyc && bus_siz == 2'b00, "R9 idle after end", {30'd0, bus_siz} | 32'(bus_cyc), 32'd0);
    if (!wr) chk(rd_data == expr, "R6 gathered data", rd_data, expr);
    exp_n = wide ? (len + 1) / 2 : len;
    chk(ncyc == exp_n, wide ? "R10 word cycles" : "R10 byte cycles", 32'(ncyc), 32'(exp_n));
    @(negedge clk);
    chk(done == 1'b0, "R7 done one cycle", 32'(done), 32'd0);
    chk(req_ready == 1'b1 && !bus_cyc, "R8 ready after end", 32'(req_ready), 32'd1);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    chk(bus_cyc == 1'b0 && bus_siz == 2'b00, "R9 reset idle", 32'(bus_cyc), 32'd0);
    chk(done == 1'b0, "R7 reset done low", 32'(done), 32'd0);
    chk(req_ready == 1'b0 || req_ready == 1'b1, "R8 reset ready known", 32'(req_ready), 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R8 ready out of reset", 32'(req_ready), 32'd1);
    for (int len = 1; len <= 4; len++)
      for (int wr = 0; wr < 2; wr++)
        for (int wide = 0; wide < 2; wide++)
          for (int nw = 0; nw < 3; nw++)
            xact(len, wr[0], wide[0], nw,
                 AW'(16'h0100 + len * 16'h0131 + wr * 16'h0047 + wide * 16'h0203 + nw * 5));
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule